// File: doc/BRIEF.md
# Two-Register Toy Processor Core

This block is a single-cycle processor core with two 8-bit working registers, A and B, and an 8-bit program counter. It reads one 16-bit instruction per clock from an internal 256-word instruction store. It splits the word into an opcode, a destination select and an immediate. It then loads the destination register with either the immediate or the result of an ALU operation. The ALU always takes A and B as its two operands.

The instruction store is filled through a write port. That port only acts while the core is held in synchronous reset. When reset is released, the core starts fetching at address 0 and advances one word per clock. After address 255 it wraps back to 0. The core has no branches, no data memory and no flags. Its registers and PC are visible on observation outputs.

Top module: `two_reg_core`

## Requirements
- R1: While `rst` is sampled high on a clock edge, the PC, A and B are all cleared to 0.
- R2: On an edge where `rst` and `load_en` are both high, `load_data` is written into the store at `load_addr`. When `rst` is low, `load_en` has no effect on the store.
- R3: The instruction word is split as follows: bits 15:12 hold the opcode, bit 11 is the destination, and bits 7:0 are the immediate. Bits 10:8 have no effect.
- R4: Opcode 4'b0000 loads the 8-bit immediate into the destination register.
- R5: Opcode 4'b0010 writes A+B, modulo 256, into the destination register.
- R6: Opcode 4'b0011 writes A−B, modulo 256, into the destination register.
- R7: Opcode 4'b0100 writes A OR B (bitwise) into the destination register.
- R8: Opcode 4'b0101 writes A AND B (bitwise) into the destination register.
- R9: A destination bit of 0 writes only A and a destination bit of 1 writes only B. The other register keeps its value.
- R10: Any other opcode writes neither register.
- R11: Outside reset, the PC increases by one on every clock and wraps from 255 to 0.
- R12: Word 0x0001 at address 0 sets A to 1, and word 0x0802 at address 1 then sets B to 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register updates on its rising edge |
| rst | input | 1 | Synchronous reset, active high; also opens the load port |
| load_en | input | 1 | Store write strobe, honoured only during reset |
| load_addr | input | 8 | Store word address for a load |
| load_data | input | 16 | Instruction word to store |
| a_out | output | 8 | Current value of register A |
| b_out | output | 8 | Current value of register B |
| pc_out | output | 8 | Current program counter |

## Verification
The bench goes after the arithmetic edges first. Add and subtract results must wrap when they cross 255 or drop below 0. A core that keeps a ninth bit, or that swaps the operands of subtract, shows a wrong A or B on the cycle after that instruction. It also fills bits 10:8 with random values and mixes in undefined opcodes, which exposes any decode that reads the wrong field or lets an unlisted opcode write a register. Each program runs past 256 cycles, so a PC that stalls or saturates at 255 is caught. While the core runs, the bench keeps toggling the load port with random writes. A store that takes those writes executes different instructions on the second pass through the program, and its register values diverge from the model.

// File: rtl/two_reg_core_pkg.sv
package two_reg_core_pkg;

   localparam int INSN_W  = 16;
   localparam int OPC_W   = 4;
   localparam int IMM_W   = 8;
   localparam int OPC_LSB = 12;
   localparam int DST_BIT = 11;

   typedef enum logic [OPC_W-1:0] {
      OPC_SET = 4'b0000,
      OPC_ADD = 4'b0010,
      OPC_SUB = 4'b0011,
      OPC_OR  = 4'b0100,
      OPC_AND = 4'b0101
   } opcode_e;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_AND = 2'b10,
      ALU_OR  = 2'b11
   } alu_op_e;

   typedef struct packed {
      logic             wr_a;
      logic             wr_b;
      logic             use_imm;
      alu_op_e          op;
      logic [IMM_W-1:0] imm;
   } ctrl_t;

endpackage

// File: rtl/insn_store.sv
module insn_store
   import two_reg_core_pkg::*;
#(
   parameter int ADDR_W = 8
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [INSN_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [INSN_W-1:0] rd_data
);

   localparam int DEPTH = 1 << ADDR_W;

   logic [INSN_W-1:0] words [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) words[wr_addr] <= wr_data;
   end

   // combinational fetch at the current PC
   assign rd_data = words[rd_addr];

endmodule

// File: rtl/insn_decode.sv
module insn_decode
   import two_reg_core_pkg::*;
(
   input  logic [INSN_W-1:0] insn,
   output ctrl_t             ctl
);

   logic [OPC_W-1:0] opc;
   logic             dst;
   logic [2:0]       unused_pad;   // R3: bits 10:8 carry no meaning

   assign opc        = insn[OPC_LSB +: OPC_W];
   assign dst        = insn[DST_BIT];
   assign unused_pad = insn[10:8];

   always_comb begin
      logic valid;
      valid       = 1'b1;
      ctl.use_imm = 1'b0;
      ctl.op      = ALU_ADD;
      ctl.imm     = insn[IMM_W-1:0];
      unique case (opc)
         OPC_SET: ctl.use_imm = 1'b1;
         OPC_ADD: ctl.op = ALU_ADD;
         OPC_SUB: ctl.op = ALU_SUB;
         OPC_OR:  ctl.op = ALU_OR;
         OPC_AND: ctl.op = ALU_AND;
         default: valid = 1'b0;      // R10
      endcase
      ctl.wr_a = valid & ~dst;       // R9
      ctl.wr_b = valid &  dst;
   end

endmodule

// File: rtl/tiny_alu.sv
module tiny_alu
   import two_reg_core_pkg::*;
#(
   parameter int W            = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  alu_op_e      op,
   input  logic [W-1:0] x,
   input  logic [W-1:0] y,
   output logic [W-1:0] r
);

   logic [W-1:0] sum_r;
   logic [W-1:0] dif_r;

   generate
      if (SHARED_ADDER) begin : g_shared
         logic         is_sub;
         logic [W-1:0] y_m;
         logic [W-1:0] res;
         assign is_sub = (op == ALU_SUB);
         assign y_m    = is_sub ? ~y : y;
         assign res    = x + y_m + {{(W-1){1'b0}}, is_sub};
         assign sum_r  = res;
         assign dif_r  = res;
      end else begin : g_split
         assign sum_r = x + y;
         assign dif_r = x - y;
      end
   endgenerate

   always_comb begin
      unique case (op)
         ALU_ADD: r = sum_r;
         ALU_SUB: r = dif_r;
         ALU_AND: r = x & y;
         ALU_OR:  r = x | y;
         default: r = '0;
      endcase
   end

endmodule

// File: rtl/two_reg_core.sv
module two_reg_core
   import two_reg_core_pkg::*;
#(
   parameter int DATA_W       = 8,
   parameter int PC_W         = 8,
   parameter bit SHARED_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              load_en,
   input  logic [PC_W-1:0]   load_addr,
   input  logic [INSN_W-1:0] load_data,
   output logic [DATA_W-1:0] a_out,
   output logic [DATA_W-1:0] b_out,
   output logic [PC_W-1:0]   pc_out
);

   localparam logic [PC_W-1:0] PC_STEP = PC_W'(1);

   generate
      if (DATA_W != IMM_W) begin : g_bad_data_w
         $error("two_reg_core: DATA_W must equal the immediate width");
      end
      if (PC_W < 1 || PC_W > 12) begin : g_bad_pc_w
         $error("two_reg_core: PC_W out of supported range");
      end
   endgenerate

   logic [PC_W-1:0]   pc_q;
   logic [DATA_W-1:0] a_q, b_q;
   logic [INSN_W-1:0] insn;
   ctrl_t             ctl;
   logic [DATA_W-1:0] alu_r;
   logic [DATA_W-1:0] wr_val;
   logic              we_a, we_b;

   insn_store #(.ADDR_W(PC_W)) u_store (
      .clk     (clk),
      .wr_en   (rst & load_en),      // R2
      .wr_addr (load_addr),
      .wr_data (load_data),
      .rd_addr (pc_q),
      .rd_data (insn)
   );

   insn_decode u_dec (
      .insn (insn),
      .ctl  (ctl)
   );

   tiny_alu #(.W(DATA_W), .SHARED_ADDER(SHARED_ADDER)) u_alu (
      .op (ctl.op),
      .x  (a_q),
      .y  (b_q),
      .r  (alu_r)
   );

   assign wr_val = ctl.use_imm ? ctl.imm : alu_r;
   assign we_a   = ctl.wr_a;
   assign we_b   = ctl.wr_b;

   always_ff @(posedge clk) begin
      if (rst) begin                 // R1
         pc_q <= '0;
         a_q  <= '0;
         b_q  <= '0;
      end else begin
         pc_q <= pc_q + PC_STEP;     // R11
         if (we_a) a_q <= wr_val;
         if (we_b) b_q <= wr_val;
      end
   end

   assign a_out  = a_q;
   assign b_out  = b_q;
   assign pc_out = pc_q;

endmodule

// File: rtl/two_reg_core_chk.sv
module two_reg_core_chk
   import two_reg_core_pkg::*;
#(
   parameter int DATA_W = 8,
   parameter int PC_W   = 8
) (
   input logic              clk,
   input logic              rst,
   input logic [INSN_W-1:0] insn,
   input logic              we_a,
   input logic              we_b,
   input logic [DATA_W-1:0] a_out,
   input logic [DATA_W-1:0] b_out,
   input logic [PC_W-1:0]   pc_out
);

   logic [OPC_W-1:0] c_opc;
   logic             c_dst;
   logic             c_known;
   assign c_opc   = insn[15:12];
   assign c_dst   = insn[11];
   assign c_known = (c_opc == 4'b0000) || (c_opc == 4'b0010) || (c_opc == 4'b0011)
                 || (c_opc == 4'b0100) || (c_opc == 4'b0101);

   p_reset_clear_r1: assert property (@(posedge clk) disable iff (rst)
      $fell(rst) |-> (pc_out == '0 && a_out == '0 && b_out == '0));

   p_pc_step_r11: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> pc_out == PC_W'($past(pc_out) + 1'b1));

   p_one_dest_r9: assert property (@(posedge clk) disable iff (rst)
      !(we_a && we_b));

   p_set_a_r4: assert property (@(posedge clk) disable iff (rst)
      (c_opc == 4'b0000 && !c_dst) |=> a_out == $past(insn[7:0]));

   p_add_b_r5: assert property (@(posedge clk) disable iff (rst)
      (c_opc == 4'b0010 && c_dst) |=> b_out == DATA_W'($past(a_out) + $past(b_out)));

   p_ignore_r10: assert property (@(posedge clk) disable iff (rst)
      !c_known |=> ($stable(a_out) && $stable(b_out)));

endmodule

bind two_reg_core two_reg_core_chk #(.DATA_W(DATA_W), .PC_W(PC_W)) u_chk (
   .clk    (clk),
   .rst    (rst),
   .insn   (insn),
   .we_a   (we_a),
   .we_b   (we_b),
   .a_out  (a_out),
   .b_out  (b_out),
   .pc_out (pc_out)
);

// File: tb/two_reg_core_tb.sv
module two_reg_core_tb;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        load_en = 1'b0;
   logic [7:0]  load_addr = '0;
   logic [15:0] load_data = '0;
   logic [7:0]  a_out, b_out, pc_out;

   always #5 clk = ~clk;

   two_reg_core u_dut (
      .clk       (clk),
      .rst       (rst),
      .load_en   (load_en),
      .load_addr (load_addr),
      .load_data (load_data),
      .a_out     (a_out),
      .b_out     (b_out),
      .pc_out    (pc_out)
   );

   int n_chk  = 0;
   int n_fail = 0;
   int cycles = 0;

   logic [15:0] prog [256];
   logic [7:0]  m_a, m_b, m_pc;

   task automatic check8(string tag, string what, logic [7:0] act, logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   function automatic string tag_of(logic [15:0] w);
      case (w[15:12])
         4'b0000: return "R4/R9";
         4'b0010: return "R5/R9";
         4'b0011: return "R6/R9";
         4'b0100: return "R7/R9";
         4'b0101: return "R8/R9";
         default: return "R10";
      endcase
   endfunction

   function automatic logic [15:0] rand_word();
      logic [3:0] op;
      case ($urandom_range(0, 9))
         0, 1:    op = 4'b0000;
         2:       op = 4'b0010;
         3:       op = 4'b0011;
         4:       op = 4'b0100;
         5:       op = 4'b0101;
         6:       op = 4'b0010;
         default: op = 4'($urandom);
      endcase
      // R3: bits 10:8 random
      return {op, 1'($urandom), 3'($urandom), 8'($urandom)};
   endfunction

   // reference step built from the requirements
   task automatic model_step();
      logic [15:0] w;
      logic [7:0]  v;
      logic        ok;
      w  = prog[m_pc];
      ok = 1'b1;
      case (w[15:12])
         4'b0000: v = w[7:0];
         4'b0010: v = m_a + m_b;
         4'b0011: v = m_a - m_b;
         4'b0100: v = m_a | m_b;
         4'b0101: v = m_a & m_b;
         default: begin v = '0; ok = 1'b0; end
      endcase
      if (ok && !w[11]) m_a = v;
      if (ok &&  w[11]) m_b = v;
      m_pc = m_pc + 8'd1;
   endtask

   task automatic load_and_reset();
      rst = 1'b1;
      for (int i = 0; i < 256; i++) begin
         load_en   = 1'b1;
         load_addr = 8'(i);
         load_data = prog[i];
         @(posedge clk); #1;
      end
      load_en = 1'b0;
      @(posedge clk); #1;
      check8("R1", "pc", pc_out, 8'h00);
      check8("R1", "a", a_out, 8'h00);
      check8("R1", "b", b_out, 8'h00);
      m_a = '0; m_b = '0; m_pc = '0;
      rst = 1'b0;
   endtask

   task automatic run(int n);
      for (int i = 0; i < n; i++) begin
         string t;
         t = tag_of(prog[m_pc]);
         // R2: load port noise while running must be ignored
         load_en   = 1'($urandom);
         load_addr = 8'($urandom);
         load_data = 16'($urandom);
         @(posedge clk); #1;
         model_step();
         check8(t, "a", a_out, m_a);
         check8(t, "b", b_out, m_b);
         check8("R11", "pc", pc_out, m_pc);
      end
      load_en = 1'b0;
   endtask

   initial begin
      void'($urandom(32'd20240611));
      for (int i = 0; i < 256; i++) prog[i] = rand_word();
      prog[0]  = 16'h0001;  // R12 A=1
      prog[1]  = 16'h0802;  // R12 B=2
      prog[2]  = 16'h2000;  // R5 A=3
      prog[3]  = 16'h3800;  // R6 B=1
      prog[4]  = 16'h00FF;  // A=255
      prog[5]  = 16'h2800;  // R5 wrap B=0
      prog[6]  = 16'h0805;  // B=5
      prog[7]  = 16'h3800;  // R6 B=250
      prog[8]  = 16'h0000;  // A=0
      prog[9]  = 16'h3000;  // R6 underflow A=6
      prog[10] = 16'hF7AA;  // R10 undefined
      prog[11] = 16'h1E33;  // R10 undefined with dest B
      prog[12] = 16'h0F12;  // R3 padding bits set, B=0x12
      prog[13] = 16'h4000;  // R7
      prog[14] = 16'h5800;  // R8
      load_and_reset();
      @(posedge clk); #1; model_step();
      check8("R12", "a after 0x0001", a_out, 8'h01);
      @(posedge clk); #1; model_step();
      check8("R12", "b after 0x0802", b_out, 8'h02);
      run(300);  // crosses the PC wrap (R11) and re-executes, exposing R2 leaks

      for (int i = 0; i < 256; i++) prog[i] = rand_word();
      load_and_reset();
      run(280);

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   always @(posedge clk) begin
      cycles <= cycles + 1;
      if (cycles > 20000) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
         $finish;
      end
   end

endmodule